// File: doc/BRIEF.md
# PTP Time-of-Day Timer with Fractional Rate Trim

This block keeps a 64-bit nanosecond time-of-day count in the style of an IEEE 1588 clock. It runs on a single system clock `clk`. Four reference sources reach it as one-cycle edge strobes that are synchronous to `clk`. A two-bit select field picks which of the four strobes drives the timer. On every selected strobe, a 32-bit phase accumulator adds a programmable addend. Each carry out of the accumulator is a nominal tick, and each tick advances the time count by a programmed period in nanoseconds. Software trims the clock rate by setting the addend to ceil(2^32 / ratio), where ratio is the reference rate over the nominal tick rate.

A prescaler divides the ticks into a square output clock. Two independent fixed-interval generators each compare the time count against a running target. When the time reaches the target, the generator raises a one-cycle interrupt and a pulse that lasts one output-clock period. The generator then moves its target forward by one span. Software programs each generator with the span minus one tick period. For example, a one-pulse-per-second setting at a 10 ns tick is 0x3B9AC9F6.

Software writes the configuration through a plain write port. It reads the time count through a two-step read, in which reading the low word latches the high word.

Top module: `ptp_tod_timer`

## Requirements
- R1: The clock-select register at address 1 (bits 1:0) picks one reference strobe. Value 0 selects `ref_en[0]` (external precision clock), 1 selects `ref_en[1]` (system clock), 2 selects `ref_en[2]` (first port transmit clock) and 3 selects `ref_en[3]` (RTC input). Strobes on the unselected inputs leave the time unchanged.
- R2: After reset the clock select is 1, so the system-clock strobe `ref_en[1]` drives the timer.
- R3: Each selected strobe adds the addend (address 2) to a 32-bit accumulator. Each carry out advances the time by the period (address 3). Over N strobes that bring the accumulator back to its start value, the time grows by (N·addend / 2^32)·period.
- R4: Writing the addend keeps the accumulator phase. Strobes after the write continue from the fraction reached under the old addend.
- R5: Bit 0 of the control register (address 0) enables the timer. While it is 0, selected strobes neither advance the time nor move the accumulator.
- R6: The time count is 64 bits and starts at 0. A read with `rd_en`=1 and `rd_hi`=0 returns the low word on `rd_data` one cycle later and latches the high word. A read with `rd_hi`=1 returns that latched high word one cycle later.
- R7: `out_clk` has a period of P ticks, where P is the prescale value (address 4) and values below 2 count as 2. `out_clk` changes only in the cycle after a tick.
- R8: Generator g (interval value at address 5+g) fires first when the time reaches the time at the write plus value plus period. It then fires once every (value + period) ns. Each firing is a one-cycle pulse on `irq_out[g]`.
- R9: Each firing raises `pulse_out[g]` in the same cycle as `irq_out[g]`. The pulse stays high for P ticks, with P as in R7.
- R10: After reset the time reads 0 and `out_clk`, `pulse_out` and `irq_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 4 | Reference edge strobes, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Time read request |
| rd_hi | input | 1 | 0 = low word (latches high word), 1 = latched high word |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| out_clk | output | 1 | Prescaled output clock |
| pulse_out | output | 2 | Fixed-interval pulses |
| irq_out | output | 2 | One-cycle interrupt per interval firing |

## Verification
A wrong accumulator phase does not show at once. It shifts which strobe produces a carry, so the time readback after a group of strobes comes out one period high or low. A wrong time count or generator target shows within one interval: the spacing between interrupts or the pulse width is off, measured in system cycles. A stuck select or enable shows as a time readback that fails to move, or moves when it should not, three cycles after the strobes stop.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  localparam int ADDR_W   = 3;
  localparam int NREF     = 4;
  localparam int SEL_W    = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ADDEND = 3'd2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRESC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IVAL0  = 3'd5;
  localparam logic [SEL_W-1:0]  SEL_SYS  = 2'd1;
endpackage

// File: rtl/ptp_tmr_regs.sv
module ptp_tmr_regs
  import ptp_tmr_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NGEN = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic                     run_en,
  output logic [SEL_W-1:0]         ref_sel,
  output logic [DW-1:0]            addend,
  output logic [DW-1:0]            period,
  output logic [DW-1:0]            prescale,
  output logic [NGEN-1:0][DW-1:0]  ival,
  output logic [NGEN-1:0]          ival_load
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      ref_sel   <= SEL_SYS;
      addend    <= '0;
      period    <= '0;
      prescale  <= '0;
      ival      <= '0;
      ival_load <= '0;
    end else begin
      ival_load <= '0;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:   run_en   <= wr_data[0];
          A_SEL:    ref_sel  <= wr_data[SEL_W-1:0];
          A_ADDEND: addend   <= wr_data;
          A_PERIOD: period   <= wr_data;
          A_PRESC:  prescale <= wr_data;
          default: ;
        endcase
        for (int g = 0; g < NGEN; g++) begin
          if (wr_addr == ADDR_W'(int'(A_IVAL0) + g)) begin
            ival[g]      <= wr_data;
            ival_load[g] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ptp_phase_accum.sv
module ptp_phase_accum
  import ptp_tmr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREF-1:0]  ref_en,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic             run_en,
  input  logic [AW-1:0]    addend,
  output logic             tick
);
  logic [AW-1:0] acc;
  logic [AW:0]   sum;
  logic          step;

  assign sum  = {1'b0, acc} + {1'b0, addend};
  assign step = run_en & ref_en[ref_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step) begin
        acc  <= sum[AW-1:0];
        tick <= sum[AW];
      end
    end
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int DW = 32,
  parameter int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] period,
  input  logic          rd_en,
  input  logic          rd_hi,
  output logic [TW-1:0] time_q,
  output logic [DW-1:0] rd_data
);
  logic [TW-DW-1:0] hi_snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q  <= '0;
      hi_snap <= '0;
      rd_data <= '0;
    end else begin
      if (tick) time_q <= time_q + TW'(period);
      if (rd_en) begin
        if (rd_hi) begin
          rd_data <= DW'(hi_snap);
        end else begin
          rd_data <= time_q[DW-1:0];
          hi_snap <= time_q[TW-1:DW];
        end
      end
    end
  end
endmodule

// File: rtl/ptp_out_divider.sv
module ptp_out_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] prescale,
  output logic [DW-1:0] eff_pres,
  output logic          out_clk
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] cnt_nxt;
  logic [DW-1:0] half;

  assign eff_pres = (prescale < DW'(2)) ? DW'(2) : prescale;
  assign half     = eff_pres >> 1;
  assign cnt_nxt  = (cnt >= eff_pres - DW'(1)) ? '0 : cnt + DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      out_clk <= 1'b0;
    end else if (tick) begin
      cnt     <= cnt_nxt;
      out_clk <= (cnt_nxt < half);
    end
  end
endmodule

// File: rtl/ptp_interval_gen.sv
module ptp_interval_gen #(
  parameter int DW = 32,
  parameter int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [TW-1:0] time_q,
  input  logic [DW-1:0] period,
  input  logic [DW-1:0] eff_pres,
  input  logic [DW-1:0] ival,
  input  logic          load,
  output logic          pulse,
  output logic          irq
);
  logic [TW-1:0] target;
  logic [TW-1:0] span;
  logic [DW-1:0] left;
  logic          armed;

  assign span = TW'(ival) + TW'(period);

  always_ff @(posedge clk) begin
    if (rst) begin
      target <= '0;
      armed  <= 1'b0;
      pulse  <= 1'b0;
      irq    <= 1'b0;
      left   <= '0;
    end else begin
      irq <= 1'b0;
      if (load) begin
        target <= time_q + span;
        armed  <= 1'b1;
        pulse  <= 1'b0;
        left   <= '0;
      end else if (armed && time_q >= target) begin
        target <= target + span;
        irq    <= 1'b1;
        pulse  <= 1'b1;
        left   <= eff_pres;
      end else if (pulse && tick) begin
        if (left <= DW'(1)) pulse <= 1'b0;
        left <= left - DW'(1);
      end
    end
  end
endmodule

// File: rtl/ptp_tod_timer.sv
module ptp_tod_timer
  import ptp_tmr_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NGEN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NREF-1:0]     ref_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  input  logic                rd_hi,
  output logic [DW-1:0]       rd_data,
  output logic                out_clk,
  output logic [NGEN-1:0]     pulse_out,
  output logic [NGEN-1:0]     irq_out
);
  localparam int TW = 2 * DW;

  logic                    run_en;
  logic [SEL_W-1:0]        ref_sel;
  logic [DW-1:0]           addend;
  logic [DW-1:0]           period;
  logic [DW-1:0]           prescale;
  logic [DW-1:0]           eff_pres;
  logic [NGEN-1:0][DW-1:0] ival;
  logic [NGEN-1:0]         ival_load;
  logic                    tick;
  logic [TW-1:0]           time_q;

  ptp_tmr_regs #(.DW(DW), .NGEN(NGEN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_en(run_en), .ref_sel(ref_sel), .addend(addend), .period(period),
    .prescale(prescale), .ival(ival), .ival_load(ival_load)
  );

  ptp_phase_accum #(.AW(DW)) u_accum (
    .clk(clk), .rst(rst), .ref_en(ref_en), .ref_sel(ref_sel),
    .run_en(run_en), .addend(addend), .tick(tick)
  );

  ptp_tod_counter #(.DW(DW), .TW(TW)) u_tod (
    .clk(clk), .rst(rst), .tick(tick), .period(period),
    .rd_en(rd_en), .rd_hi(rd_hi), .time_q(time_q), .rd_data(rd_data)
  );

  ptp_out_divider #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .prescale(prescale),
    .eff_pres(eff_pres), .out_clk(out_clk)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_ival
    ptp_interval_gen #(.DW(DW), .TW(TW)) u_gen (
      .clk(clk), .rst(rst), .tick(tick), .time_q(time_q), .period(period),
      .eff_pres(eff_pres), .ival(ival[g]), .load(ival_load[g]),
      .pulse(pulse_out[g]), .irq(irq_out[g])
    );
  end
endmodule

// File: rtl/ptp_tmr_chk.sv
module ptp_tmr_chk #(
  parameter int DW   = 32,
  parameter int NGEN = 2,
  parameter int TW   = 2 * DW
) (
  input logic            clk,
  input logic            rst,
  input logic            run_en,
  input logic            tick,
  input logic [TW-1:0]   time_q,
  input logic [DW-1:0]   period,
  input logic            rd_en,
  input logic            rd_hi,
  input logic [DW-1:0]   rd_data,
  input logic            out_clk,
  input logic [NGEN-1:0] pulse_out,
  input logic [NGEN-1:0] irq_out
);
  a_r5_disabled_no_tick: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !tick);

  a_r3_tick_adds_period: assert property (@(posedge clk) disable iff (rst)
    tick |=> time_q == $past(time_q) + TW'($past(period)));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(time_q));

  a_r6_low_word_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hi) |=> rd_data == $past(time_q[DW-1:0]));

  a_r7_outclk_after_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_clk) |-> $past(tick));

  for (genvar g = 0; g < NGEN; g++) begin : g_chk
    a_r9_pulse_with_irq: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_out[g]) |-> irq_out[g]);
  end
endmodule

bind ptp_tod_timer ptp_tmr_chk #(.DW(DW), .NGEN(NGEN)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .tick(tick), .time_q(time_q),
  .period(period), .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data),
  .out_clk(out_clk), .pulse_out(pulse_out), .irq_out(irq_out)
);

// File: tb/test_ptp_tod_timer.sv
module test_ptp_tod_timer;
  localparam int DW = 32;
  localparam int NV = 4;
  localparam logic [31:0] V_ADD [NV] = '{32'h8000_0000, 32'hC000_0000, 32'h2000_0000, 32'h4000_0000};
  localparam logic [31:0] V_PER [NV] = '{32'd10, 32'd7, 32'd25, 32'd3};
  localparam int          V_N   [NV] = '{8, 4, 16, 12};
  localparam logic [63:0] V_EXP [NV] = '{64'd40, 64'd21, 64'd50, 64'd9};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [3:0]    man_ref;
  logic          free_run;
  logic [3:0]    ref_en;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [31:0]   wr_data;
  logic          rd_en;
  logic          rd_hi;
  logic [31:0]   rd_data;
  logic          out_clk;
  logic [1:0]    pulse_out;
  logic [1:0]    irq_out;

  assign ref_en = man_ref | (free_run ? 4'b0010 : 4'b0000);

  ptp_tod_timer #(.DW(DW), .NGEN(2)) i_ptp_tod_timer (
    .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data),
    .out_clk(out_clk), .pulse_out(pulse_out), .irq_out(irq_out)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_t;
  logic [63:0] t0;
  logic [63:0] t1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); man_ref = 4'b0001 << sel;
    end
    @(negedge clk); man_ref = 4'b0000;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_word(input logic hi, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_hi = hi;
    @(negedge clk); v = rd_data; rd_en = 1'b0;
  endtask

  task automatic rd64(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd_word(1'b0, lo);
    rd_word(1'b1, hi);
    t = {hi, lo};
  endtask

  function automatic logic probe(input int which);
    case (which)
      0: probe = irq_out[0];
      1: probe = irq_out[1];
      2: probe = pulse_out[0];
      default: probe = out_clk;
    endcase
  endfunction

  task automatic wait_level(input int which, input logic lvl, output int n);
    n = 0;
    while (probe(which) !== lvl && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n, w, h, l;
    logic [31:0] v;
    rst = 1'b1; man_ref = '0; free_run = 1'b0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; rd_en = 1'b0; rd_hi = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    rd64(t0);
    chk("R10 time after reset", t0, 64'd0);
    chk("R10 outputs after reset", {59'd0, out_clk, pulse_out, irq_out}, 64'd0);

    // R3 / R2: vector table on default clock select (system strobe)
    wr(3'd0, 32'd1);
    exp_t = 64'd0;
    for (int k = 0; k < NV; k++) begin
      wr(3'd2, V_ADD[k]);
      wr(3'd3, V_PER[k]);
      strobe(1, V_N[k]);
      exp_t = exp_t + V_EXP[k];
      rd64(t0);
      chk(k == 0 ? "R2 default select on system strobe" : "R3 carry-driven advance", t0, exp_t);
    end

    // R1: select 2 ignores system strobe, follows transmit strobe
    wr(3'd2, 32'h8000_0000);
    wr(3'd3, 32'd10);
    wr(3'd1, 32'd2);
    strobe(1, 4);
    rd64(t0);
    chk("R1 unselected strobe ignored", t0, exp_t);
    strobe(2, 4);
    exp_t = exp_t + 64'd20;
    rd64(t0);
    chk("R1 select 2 follows ref_en[2]", t0, exp_t);
    wr(3'd1, 32'd0);
    strobe(3, 2);
    strobe(0, 2);
    exp_t = exp_t + 64'd10;
    rd64(t0);
    chk("R1 select 0 follows only ref_en[0]", t0, exp_t);
    wr(3'd1, 32'd1);

    // R5: enable clear holds time and phase
    wr(3'd0, 32'd0);
    strobe(1, 3);
    rd64(t0);
    chk("R5 disabled timer holds", t0, exp_t);
    wr(3'd0, 32'd1);
    strobe(1, 2);
    exp_t = exp_t + 64'd10;
    rd64(t0);
    chk("R5 phase kept across disable", t0, exp_t);

    // R4: addend change keeps accumulator phase
    strobe(1, 1);
    wr(3'd2, 32'h4000_0000);
    strobe(1, 2);
    exp_t = exp_t + 64'd10;
    rd64(t0);
    chk("R4 addend write keeps phase", t0, exp_t);

    // R6: high word snapshot taken on low read
    wr(3'd2, 32'h8000_0000);
    wr(3'd3, 32'h8000_0000);
    rd_word(1'b0, v);
    chk("R6 low word", {32'd0, v}, {32'd0, exp_t[31:0]});
    strobe(1, 4);
    rd_word(1'b1, v);
    chk("R6 high word from snapshot", {32'd0, v}, {32'd0, exp_t[63:32]});
    exp_t = exp_t + 64'h1_0000_0000;
    rd64(t0);
    chk("R6 64-bit time after wrap", t0, exp_t);

    // R7 / R8 / R9: free-running ticks every 2 cycles
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd3);
    free_run = 1'b1;
    wr(3'd5, 32'd40);
    wr(3'd6, 32'd90);
    wait_level(0, 1'b1, n);
    @(negedge clk);
    wait_level(0, 1'b1, n);
    chk("R8 generator 0 spacing", 64'(n + 1), 64'd10);
    @(negedge clk);
    wait_level(0, 1'b1, n);
    chk("R8 generator 0 spacing repeat", 64'(n + 1), 64'd10);
    chk("R8 irq one cycle", 64'(irq_out[0]), 64'd1);
    @(negedge clk);
    chk("R8 irq drops next cycle", 64'(irq_out[0]), 64'd0);
    wait_level(1, 1'b1, n);
    @(negedge clk);
    wait_level(1, 1'b1, n);
    chk("R8 generator 1 spacing", 64'(n + 1), 64'd20);
    wait_level(2, 1'b0, n);
    wait_level(2, 1'b1, n);
    wait_level(2, 1'b0, w);
    chk("R9 pulse width one output period", 64'((w == 5 || w == 6) ? 1 : 0), 64'd1);
    wait_level(3, 1'b0, n);
    wait_level(3, 1'b1, n);
    wait_level(3, 1'b0, h);
    wait_level(3, 1'b1, l);
    chk("R7 output clock period", 64'(h + l), 64'd6);
    wr(3'd4, 32'd1);
    wait_level(3, 1'b0, n);
    wait_level(3, 1'b1, n);
    wait_level(3, 1'b0, h);
    wait_level(3, 1'b1, l);
    chk("R7 prescale below 2 acts as 2", 64'(h + l), 64'd4);
    free_run = 1'b0;
    rd64(t0);
    repeat (5) @(negedge clk);
    rd64(t1);
    chk("R3 time holds without strobes", t1, t0);

    summary();
  end
endmodule